// File: doc/BRIEF.md
# Ganged Output Drive Controller

This block lets a group of port pins, wired together on the board, act as one stronger output. One master pin supplies the data value, drive strength and slew rate. A write-once configuration register names the pins that copy those settings. While the gang is active, the master and every selected pin are outputs.

For every pin the block resolves four final pad controls: output enable, data, drive strength and slew rate. It picks the winner in a fixed order. An enabled analog function comes first, then gang membership, then a digital peripheral, and finally the pin's own general-purpose port registers. The port registers and the peripheral and analog requests are plain inputs. The pad controls are combinational, so a configuration write takes effect on the cycle after it is captured.

Pins are numbered as one vector. Indices 0 to 7 are port B pins 0 to 7, and indices 8 to 15 are port C pins 0 to 7. The master is port C pin 0, which is index 8.

Top module: `gang_drive_ctl`

## Requirements
- R1: After reset the configuration register reads 0. With no peripheral or analog request, every pin's pad controls equal its own port registers.
- R2: The first configuration write after reset is stored and reads back from the next cycle on.
- R3: Every later write is ignored until the next reset. Reset clears the lock, so the register can be written once more.
- R4: Bit 0 of the configuration register is the gang enable. Select bits 7, 6, 5 and 4 add port B pins 5, 4, 3 and 2 (indices 5, 4, 3, 2). Select bits 3, 2 and 1 add port C pins 3, 2 and 1 (indices 11, 10, 9). No other pin can join the gang.
- R5: With the gang enabled, the master pin (index 8) is an output whatever its direction bit holds, and it keeps its own data, drive and slew bits.
- R6: With the gang enabled, each selected pin is an output and takes the master's data, drive-strength and slew-rate bits.
- R7: A gang member ignores a peripheral request on its pin.
- R8: A pin with analog enabled has output enable 0 and data 0, whatever the gang or peripheral state. Its drive and slew follow its own port bits.
- R9: With the gang enable clear, the select bits have no effect.
- R10: Without analog or gang, a peripheral request sets output enable and data from the peripheral. Drive and slew still come from the pin's own port bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration value |
| port_dout | input | NUM_PINS | Port data bits |
| port_dir | input | NUM_PINS | Port direction bits (1 = output) |
| port_drv | input | NUM_PINS | Port high-drive bits |
| port_slew | input | NUM_PINS | Port slew-limit bits |
| per_sel | input | NUM_PINS | Peripheral owns the pin |
| per_oe | input | NUM_PINS | Peripheral output enable |
| per_dout | input | NUM_PINS | Peripheral data |
| ana_en | input | NUM_PINS | Analog function enabled on the pin |
| pad_oe | output | NUM_PINS | Final output enable |
| pad_dout | output | NUM_PINS | Final output data |
| pad_drv | output | NUM_PINS | Final drive strength |
| pad_slew | output | NUM_PINS | Final slew rate |

## Verification
The bench sweeps all 256 configuration values. For each one it sends a second, conflicting write, so a lock that fails lets the second value show up in the readback. Pin inputs are computed per value so that analog, peripheral and direction bits collide with gang membership. A design that reversed the analog and gang priority would drive analog pins. One that misrouted a select bit would gang the wrong pin. One that ignored the enable would gang pins while the enable is 0.

// File: rtl/gang_pkg.sv
package gang_pkg;

    localparam int unsigned CFG_W      = 8;
    localparam int unsigned PB_BASE    = 0;
    localparam int unsigned PC_BASE    = 8;
    localparam int unsigned MASTER_IDX = PC_BASE;
    localparam int unsigned MIN_PINS   = PC_BASE + 8;

    typedef struct packed {
        logic [CFG_W-1:1] sel;
        logic             en;
    } gang_cfg_t;

    typedef struct packed {
        logic oe;
        logic dout;
        logic drv;
        logic slew;
    } pin_ctl_t;

    // Select bit that adds pin p to the gang; 0 means the pin cannot join.
    function automatic int unsigned sel_bit_of_pin(input int unsigned p);
        if (p >= PC_BASE + 1 && p <= PC_BASE + 3)
            return p - PC_BASE;
        if (p >= PB_BASE + 2 && p <= PB_BASE + 5)
            return p - PB_BASE + 2;
        return 0;
    endfunction

endpackage

// File: rtl/gang_cfg_reg.sv
module gang_cfg_reg
    import gang_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output gang_cfg_t        cfg_q
);

    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
        end else if (we && !locked_q) begin
            cfg_q    <= gang_cfg_t'(wdata);
            locked_q <= 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0 && !locked_q));

    assert_first_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !locked_q) |=> (cfg_q == $past(wdata) && locked_q));

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> ($stable(cfg_q) && locked_q));

endmodule

// File: rtl/gang_pin_mux.sv
module gang_pin_mux
    import gang_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     gang_en,
    input  logic     gang_member,
    input  logic     m_dout,
    input  logic     m_drv,
    input  logic     m_slew,
    input  pin_ctl_t own,
    input  logic     per_sel,
    input  logic     per_oe,
    input  logic     per_dout,
    input  logic     ana_en,
    output pin_ctl_t pad
);

    logic ganged;
    assign ganged = gang_en && gang_member;

    always_comb begin
        if (ana_en) begin
            pad = '{oe: 1'b0, dout: 1'b0, drv: own.drv, slew: own.slew};
        end else if (ganged) begin
            pad = '{oe: 1'b1, dout: m_dout, drv: m_drv, slew: m_slew};
        end else if (per_sel) begin
            pad = '{oe: per_oe, dout: per_dout, drv: own.drv, slew: own.slew};
        end else begin
            pad = own;
        end
    end

    assert_analog_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ana_en |-> (!pad.oe && !pad.dout));

    assert_gang_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (ganged && !ana_en) |-> (pad.oe && pad.dout == m_dout &&
                                 pad.drv == m_drv && pad.slew == m_slew));

    assert_gang_over_per_R7: assert property (@(posedge clk) disable iff (rst)
        (ganged && !ana_en && per_sel) |-> pad.oe);

    assert_idle_passthru_R9: assert property (@(posedge clk) disable iff (rst)
        (!gang_en && !ana_en && !per_sel) |-> (pad == own));

endmodule

// File: rtl/gang_drive_ctl.sv
module gang_drive_ctl
    import gang_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic [NUM_PINS-1:0] port_dout,
    input  logic [NUM_PINS-1:0] port_dir,
    input  logic [NUM_PINS-1:0] port_drv,
    input  logic [NUM_PINS-1:0] port_slew,
    input  logic [NUM_PINS-1:0] per_sel,
    input  logic [NUM_PINS-1:0] per_oe,
    input  logic [NUM_PINS-1:0] per_dout,
    input  logic [NUM_PINS-1:0] ana_en,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_dout,
    output logic [NUM_PINS-1:0] pad_drv,
    output logic [NUM_PINS-1:0] pad_slew
);

    initial begin
        assert (NUM_PINS >= MIN_PINS) else $error("NUM_PINS too small for gang map");
    end

    gang_cfg_t cfg_q;

    gang_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign cfg_rdata = cfg_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int unsigned SB = sel_bit_of_pin(p);
        logic     member;
        pin_ctl_t own_ctl;
        pin_ctl_t pad_ctl;

        if (p == MASTER_IDX) begin : g_master
            assign member = 1'b1;
        end else if (SB != 0) begin : g_sel
            assign member = cfg_q.sel[SB];
        end else begin : g_none
            assign member = 1'b0;
        end

        assign own_ctl = '{oe: port_dir[p], dout: port_dout[p],
                           drv: port_drv[p], slew: port_slew[p]};

        gang_pin_mux u_mux (
            .clk         (clk),
            .rst         (rst),
            .gang_en     (cfg_q.en),
            .gang_member (member),
            .m_dout      (port_dout[MASTER_IDX]),
            .m_drv       (port_drv[MASTER_IDX]),
            .m_slew      (port_slew[MASTER_IDX]),
            .own         (own_ctl),
            .per_sel     (per_sel[p]),
            .per_oe      (per_oe[p]),
            .per_dout    (per_dout[p]),
            .ana_en      (ana_en[p]),
            .pad         (pad_ctl)
        );

        assign pad_oe[p]   = pad_ctl.oe;
        assign pad_dout[p] = pad_ctl.dout;
        assign pad_drv[p]  = pad_ctl.drv;
        assign pad_slew[p] = pad_ctl.slew;

        if (p == MASTER_IDX) begin : g_master_chk
            assert_master_out_R5: assert property (@(posedge clk) disable iff (rst)
                (cfg_q.en && !ana_en[p]) |-> (pad_oe[p] && pad_dout[p] == port_dout[p]));
        end else if (SB == 0) begin : g_outsider_chk
            assert_non_member_R4: assert property (@(posedge clk) disable iff (rst)
                (!ana_en[p] && !per_sel[p]) |-> (pad_oe[p] == port_dir[p]));
        end
    end

endmodule

// File: tb/gang_drive_ctl_test.sv
module gang_drive_ctl_test;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_wdata = '0;
    logic [7:0]   cfg_rdata;
    logic [N-1:0] port_dout = '0, port_dir = '0, port_drv = '0, port_slew = '0;
    logic [N-1:0] per_sel = '0, per_oe = '0, per_dout = '0, ana_en = '0;
    logic [N-1:0] pad_oe, pad_dout, pad_drv, pad_slew;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gang_drive_ctl #(.NUM_PINS(N)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .port_dout(port_dout), .port_dir(port_dir),
        .port_drv(port_drv), .port_slew(port_slew), .per_sel(per_sel),
        .per_oe(per_oe), .per_dout(per_dout), .ana_en(ana_en),
        .pad_oe(pad_oe), .pad_dout(pad_dout), .pad_drv(pad_drv),
        .pad_slew(pad_slew)
    );

    // R4 map, written as a lookup independent of the RTL formula
    function automatic bit in_gang(input int p, input logic [7:0] c);
        case (p)
            8:  return 1'b1;
            9:  return c[1];
            10: return c[2];
            11: return c[3];
            2:  return c[4];
            3:  return c[5];
            4:  return c[6];
            5:  return c[7];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_rd(input logic [7:0] exp, input string req);
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s readback act=%02h exp=%02h", req, cfg_rdata, exp);
        end
    endtask

    task automatic check_pins(input logic [7:0] c, input string req);
        for (int p = 0; p < N; p++) begin
            logic [3:0] exp, act;
            string r;
            if (ana_en[p]) begin
                exp = {1'b0, 1'b0, port_drv[p], port_slew[p]}; r = "R8";
            end else if (c[0] && in_gang(p, c)) begin
                exp = {1'b1, port_dout[8], port_drv[8], port_slew[8]};
                r = (p == 8) ? "R5" : (per_sel[p] ? "R7" : "R6");
            end else if (per_sel[p]) begin
                exp = {per_oe[p], per_dout[p], port_drv[p], port_slew[p]}; r = "R10";
            end else begin
                exp = {port_dir[p], port_dout[p], port_drv[p], port_slew[p]};
                r = c[0] ? "R4" : "R9";
            end
            if (req.len() != 0) r = req;
            act = {pad_oe[p], pad_dout[p], pad_drv[p], pad_slew[p]};
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s pin %0d cfg=%02h {oe,d,drv,slew} act=%b exp=%b",
                         r, p, c, act, exp);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cfg_we = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_pattern(input int v, input int k);
        logic [31:0] h;
        h = 32'(v) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15 + 32'h1234567;
        port_dout = h[15:0];
        port_dir  = h[31:16];
        h = h * 32'h2545F491 + 32'h3C6EF372;
        port_drv  = h[15:0];
        port_slew = h[31:16];
        h = h * 32'h2545F491 + 32'hA54FF53A;
        per_sel   = h[15:0] & 16'h5A5A;
        per_oe    = h[31:16];
        h = h * 32'h2545F491 + 32'h510E527F;
        per_dout  = h[15:0];
        ana_en    = (k == 0) ? 16'h0000 : (h[31:16] & h[23:8] & 16'h0F3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        set_pattern(7, 0);
        #1;
        check_rd(8'h00, "R1");
        check_pins(8'h00, "R1");

        // reset reopens the lock (R3)
        do_write(8'hFF);
        do_reset();
        check_rd(8'h00, "R1");
        do_write(8'h3B);
        #1; check_rd(8'h3B, "R3");

        for (int v = 0; v < 256; v++) begin
            do_reset();
            do_write(8'(v));
            #1; check_rd(8'(v), "R2");
            do_write(~8'(v));
            do_write(8'(v) ^ 8'h55);
            #1; check_rd(8'(v), "R3");
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                set_pattern(v, k);
                #1;
                check_pins(8'(v), "");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule